// File: doc/BRIEF.md
# Dual-Port Audio Interrupt Aggregator

This block merges FIFO threshold events from two audio ports into a single interrupt line. Each port has a playback source and a capture source, which gives four sources in all. A source's event is latched into a pending-status register. The source raises the interrupt only when both of two independent enable registers allow it. Software reads the pending status. It clears pending bits in one of two ways: it writes back a value that has zeros at the bits to clear, or it pulses the interrupt-reset control.

The block also holds a clock-enable register with one gate per port and a soft-reset register. The soft-reset register carries a global reset, an interrupt-logic reset and one reset per port. Each of these resets is active while its bit reads 0, and software releases it by writing 1. Register accesses come from an external decoder: a write strobe with a write select and data, and a separate read select whose data returns in the same cycle.

Top module: `audio_irq_agg`

## Requirements
- R1: Source events `evt_i[0]` (port A playback), `evt_i[1]` (port A capture), `evt_i[2]` (port B playback) and `evt_i[3]` (port B capture) set status bits 0, 4, 8 and 12 respectively. A set bit stays set until software or a reset clears it.
- R2: `irq_o` is a register that goes high one cycle after some status bit is set at the same position in both enable registers (select 1 and select 2). If no position is set in both enable registers, `irq_o` stays low.
- R3: A write to the status register (select 0) clears every status bit written as 0 and leaves every bit written as 1 unchanged. Writing zero therefore clears all pending sources.
- R4: An event that arrives in the same cycle as a software clear of its status bit leaves that bit set.
- R5: The soft-reset register (select 4) comes out of hardware reset as 0x0000, with all resets active. Bit 0 is the global reset, bit 4 the interrupt reset, bit 8 the port A reset and bit 12 the port B reset. Writing 1 to a bit releases that reset, and the register reads back what was written.
- R6: While soft-reset bit 4 is 0, the status register is held at zero, `irq_o` is held low and events are dropped. This hold takes effect one cycle after the write that clears the bit.
- R7: `port_rst_n_o[0]` (port A) is low while soft-reset bit 8 or bit 0 is 0. `port_rst_n_o[1]` (port B) is low while bit 12 or bit 0 is 0. Events from a port held in reset do not set status.
- R8: While soft-reset bit 0 is 0, the status, both enable registers and the clock enables are held at zero, and writes to those registers have no effect.
- R9: Bit 0 of the clock-enable register (select 3) drives `clk_en_o[0]` for port A, and bit 4 drives `clk_en_o[1]` for port B.
- R10: The enable and clock-enable registers keep only their defined bits (0, 4, 8 and 12 for the enables; 0 and 4 for the clock enables). Every other bit reads as 0, and unused selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| evt_i | input | 4 | Threshold event pulses: A play, A capture, B play, B capture |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write register select |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 3 | Read register select |
| rd_data_o | output | 16 | Read data for rd_sel_i, same cycle |
| irq_o | output | 1 | Registered interrupt request |
| clk_en_o | output | 2 | Per-port clock gate enables, [0]=A, [1]=B |
| port_rst_n_o | output | 2 | Per-port active-low resets, [0]=A, [1]=B |

## Verification
A status bit that is lost or wrongly set appears on `rd_data_o` in the cycle right after the event or write that caused it. Its effect on `irq_o` appears one cycle later. An enable or reset register that decodes the wrong bit shows up on `clk_en_o`, `port_rst_n_o` or the read-back value as soon as the write lands. A reset that does not hold state at zero is exposed by events and writes applied during the hold, which must leave reads at zero.

// File: rtl/audio_irq_agg.sv
module audio_irq_agg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  evt_i,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_sel_i,
  input  logic [15:0] wr_data_i,
  input  logic [2:0]  rd_sel_i,
  output logic [15:0] rd_data_o,
  output logic        irq_o,
  output logic [1:0]  clk_en_o,
  output logic [1:0]  port_rst_n_o
);
  localparam logic [15:0] SRC_MASK = 16'h1111;
  localparam logic [2:0]  SEL_STAT = 3'd0;
  localparam logic [2:0]  SEL_ENA  = 3'd1;
  localparam logic [2:0]  SEL_ENB  = 3'd2;
  localparam logic [2:0]  SEL_CKE  = 3'd3;
  localparam logic [2:0]  SEL_SRST = 3'd4;

  function automatic logic [15:0] spread4(input logic [3:0] v);
    return {3'b0, v[3], 3'b0, v[2], 3'b0, v[1], 3'b0, v[0]};
  endfunction

  logic [15:0] stat_q, ena_q, enb_q, srst_q;
  logic [1:0]  cke_q;
  logic        irq_q;

  wire glb_hold = ~srst_q[0];
  wire irq_hold = ~srst_q[4];

  assign port_rst_n_o = {srst_q[12] & srst_q[0], srst_q[8] & srst_q[0]};
  assign clk_en_o     = cke_q;
  assign irq_o        = irq_q;

  wire [3:0]  evt_ok = evt_i & {{2{port_rst_n_o[1]}}, {2{port_rst_n_o[0]}}};
  wire [15:0] evt_v  = spread4(evt_ok);

  wire wr_stat = wr_en_i && (wr_sel_i == SEL_STAT);
  wire wr_ena  = wr_en_i && (wr_sel_i == SEL_ENA);
  wire wr_enb  = wr_en_i && (wr_sel_i == SEL_ENB);
  wire wr_cke  = wr_en_i && (wr_sel_i == SEL_CKE);
  wire wr_srst = wr_en_i && (wr_sel_i == SEL_SRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   stat_q <= '0;
    else if (glb_hold || irq_hold) stat_q <= '0;
    else                          stat_q <= (wr_stat ? (stat_q & wr_data_i) : stat_q) | evt_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      enb_q <= '0;
      cke_q <= '0;
    end else if (glb_hold) begin
      ena_q <= '0;
      enb_q <= '0;
      cke_q <= '0;
    end else begin
      if (wr_ena) ena_q <= wr_data_i & SRC_MASK;
      if (wr_enb) enb_q <= wr_data_i & SRC_MASK;
      if (wr_cke) cke_q <= {wr_data_i[4], wr_data_i[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       srst_q <= '0;
    else if (wr_srst) srst_q <= wr_data_i & SRC_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    irq_q <= 1'b0;
    else if (glb_hold || irq_hold) irq_q <= 1'b0;
    else                           irq_q <= |(stat_q & ena_q & enb_q);
  end

  always_comb begin
    case (rd_sel_i)
      SEL_STAT: rd_data_o = stat_q;
      SEL_ENA:  rd_data_o = ena_q;
      SEL_ENB:  rd_data_o = enb_q;
      SEL_CKE:  rd_data_o = {11'b0, cke_q[1], 3'b0, cke_q[0]};
      SEL_SRST: rd_data_o = srst_q;
      default:  rd_data_o = '0;
    endcase
  end

  AST_NEW_BIT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(evt_v)) == 16'h0); // R1
  AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $past((ena_q & enb_q) == 16'h0) |-> !irq_o); // R2
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_v != 16'h0) && !glb_hold && !irq_hold) |=> ((stat_q & $past(evt_v)) == $past(evt_v))); // R4
  AST_IRQ_RESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hold |=> (stat_q == 16'h0 && !irq_o)); // R6
  AST_PORT_RESET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    glb_hold |-> (port_rst_n_o == 2'b00)); // R7
  AST_GLOBAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    glb_hold |=> (ena_q == 16'h0 && enb_q == 16'h0 && clk_en_o == 2'b00)); // R8
endmodule

// File: tb/audio_irq_agg_tb_top.sv
module audio_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  rd_sel_i = '0;
  logic [15:0] rd_data_o;
  logic        irq_o;
  logic [1:0]  clk_en_o;
  logic [1:0]  port_rst_n_o;

  always #5 clk = ~clk;

  audio_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o), .clk_en_o(clk_en_o),
    .port_rst_n_o(port_rst_n_o)
  );

  typedef struct {
    int          kind;
    logic [2:0]  sel;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = q.pop_front();
      rd_sel_i = it.sel;
      #1;
      case (it.kind)
        0: got = rd_data_o;
        1: got = {15'b0, irq_o};
        default: got = {12'b0, clk_en_o, port_rst_n_o};
      endcase
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d sel=%0d actual=%h expected=%h", it.req, it.kind, it.sel, got, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d, input logic [3:0] e = 4'b0);
    tick();
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d; evt_i = e;
    tick();
    wr_en_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [3:0] e);
    tick();
    evt_i = e;
    tick();
    evt_i = '0;
  endtask

  task automatic exp_rd(input logic [2:0] s, input logic [15:0] e, input string r);
    item_t it;
    it.kind = 0; it.sel = s; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic exp_irq(input logic e, input string r);
    item_t it;
    it.kind = 1; it.sel = 3'd0; it.exp = {15'b0, e}; it.req = r;
    q.push_back(it);
  endtask

  task automatic exp_pins(input logic [1:0] cke, input logic [1:0] prn, input string r);
    item_t it;
    it.kind = 2; it.sel = 3'd0; it.exp = {12'b0, cke, prn}; it.req = r;
    q.push_back(it);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tick();
    exp_rd(3'd4, 16'h0000, "R5");
    exp_rd(3'd0, 16'h0000, "R5");
    exp_irq(1'b0, "R5");
    exp_pins(2'b00, 2'b00, "R7");
    idle(1);

    pulse(4'b1111);
    wr(3'd1, 16'hFFFF);
    exp_rd(3'd0, 16'h0000, "R8");
    exp_rd(3'd1, 16'h0000, "R8");
    idle(1);

    wr(3'd4, 16'h1111);
    exp_rd(3'd4, 16'h1111, "R5");
    wr(3'd1, 16'hFFFF);
    exp_rd(3'd1, 16'h1111, "R10");
    wr(3'd2, 16'h0001);
    wr(3'd3, 16'hFFFF);
    exp_rd(3'd3, 16'h0011, "R10");
    exp_rd(3'd6, 16'h0000, "R10");
    exp_pins(2'b11, 2'b11, "R9");

    pulse(4'b0100);
    exp_rd(3'd0, 16'h0100, "R1");
    idle(1);
    exp_irq(1'b0, "R2");
    pulse(4'b0001);
    exp_rd(3'd0, 16'h0101, "R1");
    exp_irq(1'b0, "R2");
    idle(1);
    exp_irq(1'b1, "R2");

    wr(3'd0, 16'h0001);
    exp_rd(3'd0, 16'h0001, "R3");
    idle(1);
    exp_irq(1'b1, "R3");

    wr(3'd0, 16'h0000, 4'b1000);
    exp_rd(3'd0, 16'h1000, "R4");
    idle(1);
    exp_irq(1'b0, "R2");
    wr(3'd2, 16'h1000);
    idle(1);
    exp_irq(1'b1, "R2");
    wr(3'd0, 16'h0000);
    exp_rd(3'd0, 16'h0000, "R3");
    idle(1);
    exp_irq(1'b0, "R3");

    wr(3'd2, 16'h0010);
    pulse(4'b0010);
    exp_rd(3'd0, 16'h0010, "R1");
    idle(1);
    exp_irq(1'b1, "R2");
    wr(3'd4, 16'h1101);
    idle(1);
    exp_rd(3'd0, 16'h0000, "R6");
    exp_irq(1'b0, "R6");
    pulse(4'b0010);
    exp_rd(3'd0, 16'h0000, "R6");
    exp_rd(3'd4, 16'h1101, "R5");
    wr(3'd4, 16'h1111);
    pulse(4'b0010);
    exp_rd(3'd0, 16'h0010, "R6");

    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h1011);
    exp_pins(2'b11, 2'b10, "R7");
    pulse(4'b1001);
    exp_rd(3'd0, 16'h1000, "R7");
    pulse(4'b0010);
    exp_rd(3'd0, 16'h1000, "R7");
    wr(3'd4, 16'h0111);
    exp_pins(2'b11, 2'b01, "R7");
    pulse(4'b0100);
    exp_rd(3'd0, 16'h1000, "R7");
    wr(3'd4, 16'h1111);

    wr(3'd4, 16'h1110);
    idle(1);
    exp_rd(3'd0, 16'h0000, "R8");
    exp_rd(3'd1, 16'h0000, "R8");
    exp_rd(3'd2, 16'h0000, "R8");
    exp_pins(2'b00, 2'b00, "R8");
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h0011);
    exp_rd(3'd2, 16'h0000, "R8");
    exp_rd(3'd3, 16'h0000, "R8");
    exp_irq(1'b0, "R8");
    wr(3'd4, 16'h1111);
    exp_rd(3'd1, 16'h0000, "R8");
    exp_pins(2'b00, 2'b11, "R8");
    wr(3'd3, 16'h0010);
    exp_pins(2'b10, 2'b11, "R9");

    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule